// File: doc/BRIEF.md
# Four-Level PAM Transition-Gated Early/Late Phase Detector

This block is the digital decision stage of a bang-bang phase detector for a receiver that carries four amplitude levels per symbol. Once per symbol period it receives two thermometer words. One comes from the comparators that sample the mid-symbol (data) instant. The other comes from the comparators that sample the boundary (edge) instant between that symbol and the one before it. It decodes the current level and holds the previous one. From the pair it decides whether the boundary just crossed has a well-defined crossing point.

Only four level pairs qualify, in either direction. Two are the symmetric swings around zero. The other two skip one level and cross the threshold halfway between their two levels. For a qualifying boundary, the block reads the edge comparator whose threshold lies at the midpoint of that pair. It emits a one-cycle early or late pulse, and a valid flag marks each cycle that carries a phase update. Every other boundary is silent. The pulses feed a charge pump or a digital loop filter outside the block.

Top module: `pam4_edge_pd`

## Requirements
- R1: Level index is the number of set bits in `dataTherm` (bit 0 set above −1, bit 1 above 0, bit 2 above +1), so index 0..3 stands for −1.5, −0.5, +0.5, +1.5.
- R2: A boundary between index 0 and 3, or between 1 and 2 (either direction), is qualifying and uses edge bit 1 (edge threshold 0).
- R3: A boundary between index 3 and 1 (either direction) is qualifying and uses edge bit 2 (edge threshold +0.5).
- R4: A boundary between index 0 and 2 (either direction) is qualifying and uses edge bit 0 (edge threshold −0.5); edge bit 1 and bit 2 in `edgeTherm` are thresholds 0 and +0.5.
- R5: On a qualifying boundary, `early` pulses when the selected edge bit lies on the previous symbol's side of its threshold, and `late` pulses when it lies on the current symbol's side.
- R6: A repeated level and every non-qualifying pair (0↔1, 2↔3) give no `early`, `late` or `updValid`.
- R7: `early` and `late` are never high in the same cycle.
- R8: `updValid` is high exactly when `early` or `late` is high.
- R9: Reset (`rstN` low, asynchronous) clears all outputs and marks the previous level as unknown, so the first symbol after reset produces no update.
- R10: Outputs are registered and reflect the inputs presented before the immediately preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataTherm | input | 3 | Data-instant comparator thermometer word |
| edgeTherm | input | 3 | Edge-instant comparator word (thresholds −0.5, 0, +0.5) |
| early | output | 1 | Sampling clock is early; one-cycle pulse |
| late | output | 1 | Sampling clock is late; one-cycle pulse |
| updValid | output | 1 | A phase update is present this cycle |

## Verification
Two things can fall in the same cycle. One symbol can close one qualifying boundary and open the next, and the same cycle also chooses between the early and late results. The bench drives back-to-back qualifying swings, for example 3→0→3→1→3, with edge values placed between two edge thresholds. A wrong threshold or a stale previous level then changes the pulse direction. A behavioural model with integer levels and an analog edge value predicts every cycle, and each output is compared one clock after its inputs.

// File: rtl/pam_pd_pkg.sv
package pam_pd_pkg;

  typedef enum logic [1:0] {
    THR_LOW  = 2'd0,
    THR_ZERO = 2'd1,
    THR_HIGH = 2'd2
  } edgeThr_e;

  typedef struct packed {
    logic     qualify;
    logic     prevAbove;
    edgeThr_e thrSel;
  } pdStrobe_t;

endpackage

// File: rtl/pam_pd_ctrl.sv
module pam_pd_ctrl
  import pam_pd_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int IDX_W      = $clog2(NUM_LEVELS)
) (
  input  logic             prevOk,
  input  logic [IDX_W-1:0] prevIdx,
  input  logic [IDX_W-1:0] curIdx,
  output pdStrobe_t        strobes
);

  localparam logic [IDX_W:0]   SYM_SUM  = (IDX_W+1)'(NUM_LEVELS - 1);
  localparam logic [IDX_W-1:0] SKIP_GAP = IDX_W'(2);

  logic [IDX_W:0]   pairSum;
  logic [IDX_W-1:0] gapAbs;
  logic             isSymmetric;
  logic             isSkipOne;

  always_comb begin
    pairSum     = {1'b0, prevIdx} + {1'b0, curIdx};
    gapAbs      = (prevIdx > curIdx) ? (prevIdx - curIdx) : (curIdx - prevIdx);
    isSymmetric = (prevIdx != curIdx) && (pairSum == SYM_SUM);
    isSkipOne   = (gapAbs == SKIP_GAP);

    strobes.qualify   = prevOk && (isSymmetric || isSkipOne);
    strobes.prevAbove = (prevIdx > curIdx);
    if (isSymmetric)
      strobes.thrSel = THR_ZERO;
    else if (pairSum > SYM_SUM)
      strobes.thrSel = THR_HIGH;
    else
      strobes.thrSel = THR_LOW;
  end

  // R6: a repeated level can never be passed on as qualifying
  always_comb begin
    if (strobes.qualify)
      assert_qual_differs_R6 : assert (prevIdx != curIdx);
  end

endmodule

// File: rtl/pam_pd_dp.sv
module pam_pd_dp
  import pam_pd_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int THERM_W    = NUM_LEVELS - 1,
  parameter int IDX_W      = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THERM_W-1:0] dataTherm,
  input  logic [THERM_W-1:0] edgeTherm,
  input  pdStrobe_t          strobes,
  output logic               prevOk,
  output logic [IDX_W-1:0]   prevIdx,
  output logic [IDX_W-1:0]   curIdx,
  output logic               early,
  output logic               late,
  output logic               updValid
);

  localparam int BIT_LOW  = 0;
  localparam int BIT_ZERO = THERM_W / 2;
  localparam int BIT_HIGH = THERM_W - 1;

  logic edgeAbove;

  always_comb begin
    curIdx = IDX_W'($countones(dataTherm));
    unique case (strobes.thrSel)
      THR_LOW:  edgeAbove = edgeTherm[BIT_LOW];
      THR_HIGH: edgeAbove = edgeTherm[BIT_HIGH];
      default:  edgeAbove = edgeTherm[BIT_ZERO];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOk  <= 1'b0;
      prevIdx <= '0;
    end else begin
      prevOk  <= 1'b1;
      prevIdx <= curIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      early    <= 1'b0;
      late     <= 1'b0;
      updValid <= 1'b0;
    end else begin
      early    <= strobes.qualify && (edgeAbove == strobes.prevAbove);
      late     <= strobes.qualify && (edgeAbove != strobes.prevAbove);
      updValid <= strobes.qualify;
    end
  end

  assert_excl_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !(early && late));

  assert_valid_match_R8 : assert property (@(posedge clk) disable iff (!rstN)
    updValid == (early || late));

  assert_first_after_reset_R9 : assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(prevOk));

  assert_nonqual_silent_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.qualify |=> (!early && !late));

  assert_latency_R10 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.qualify |=> updValid);

endmodule

// File: rtl/pam4_edge_pd.sv
module pam4_edge_pd
  import pam_pd_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int THERM_W    = NUM_LEVELS - 1,
  parameter int IDX_W      = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THERM_W-1:0] dataTherm,
  input  logic [THERM_W-1:0] edgeTherm,
  output logic               early,
  output logic               late,
  output logic               updValid
);

  pdStrobe_t        strobes;
  logic             prevOk;
  logic [IDX_W-1:0] prevIdx;
  logic [IDX_W-1:0] curIdx;

  pam_pd_ctrl #(
    .NUM_LEVELS(NUM_LEVELS),
    .IDX_W     (IDX_W)
  ) uCtrl (
    .prevOk (prevOk),
    .prevIdx(prevIdx),
    .curIdx (curIdx),
    .strobes(strobes)
  );

  pam_pd_dp #(
    .NUM_LEVELS(NUM_LEVELS),
    .THERM_W   (THERM_W),
    .IDX_W     (IDX_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dataTherm(dataTherm),
    .edgeTherm(edgeTherm),
    .strobes  (strobes),
    .prevOk   (prevOk),
    .prevIdx  (prevIdx),
    .curIdx   (curIdx),
    .early    (early),
    .late     (late),
    .updValid (updValid)
  );

endmodule

// File: tb/tb_pam4_edge_pd.sv
module tb_pam4_edge_pd;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] dataTherm = '0;
  logic [2:0] edgeTherm = '0;
  logic       early, late, updValid;

  int checks = 0;
  int fails  = 0;
  int refPrev = -1;
  bit finished = 0;

  always #4 clk = ~clk;

  pam4_edge_pd dut (
    .clk(clk), .rstN(rstN), .dataTherm(dataTherm), .edgeTherm(edgeTherm),
    .early(early), .late(late), .updValid(updValid)
  );

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  // Edge voltage ev is in units of 0.25; thresholds -0.5, 0, +0.5 (R4)
  function automatic logic [2:0] edgeWord(input int ev);
    return {ev > 2, ev > 0, ev > -2};
  endfunction

  // one symbol: drive at negedge, compare one clock later (R10)
  task automatic step(input int lvl, input int ev);
    int  thrV;
    bit  qual, above, expE, expL;
    string tag;
    dataTherm = 3'((1 << lvl) - 1);   // R1 thermometer encoding
    edgeTherm = edgeWord(ev);
    qual = 0; tag = "R6"; thrV = 0;
    if (refPrev < 0) tag = "R9";
    else if (refPrev + lvl == 3 && refPrev != lvl) begin qual = 1; thrV = 0; tag = "R2"; end
    else if ((refPrev == 3 && lvl == 1) || (refPrev == 1 && lvl == 3)) begin qual = 1; thrV = 2; tag = "R3"; end
    else if ((refPrev == 0 && lvl == 2) || (refPrev == 2 && lvl == 0)) begin qual = 1; thrV = -2; tag = "R4"; end
    above = ev > thrV;
    expE = qual && (above == (refPrev > lvl));
    expL = qual && (above != (refPrev > lvl));
    refPrev = lvl;
    @(posedge clk);
    @(negedge clk);
    check({tag, "/R5/R10"}, early, expE, "early");
    check({tag, "/R5/R10"}, late, expL, "late");
    check("R8", updValid, expE | expL, "updValid");
    check("R7", early & late, 1'b0, "early&late");
  endtask

  task automatic doReset();
    rstN = 1'b0;
    refPrev = -1;
    repeat (2) @(negedge clk);
    check("R9", early, 1'b0, "early in reset");
    check("R9", late, 1'b0, "late in reset");
    check("R9", updValid, 1'b0, "updValid in reset");
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    step(3, -1);   // R9 first symbol after reset: silent
    step(0, -1);   // R2 3->0 below zero: late
    step(3, -1);   // R2 0->3 below zero: early
    step(1, 1);    // R3 3->1 below +0.5: late
    step(3, 3);    // R3 1->3 above +0.5: late
    step(1, 3);    // R3 3->1 above +0.5: early
    step(2, 1);    // R2 1->2 above zero: late
    step(1, 1);    // R2 2->1 above zero: early
    step(1, 5);    // R6 repeat
    step(0, -1);   // R6 1->0
    step(2, -1);   // R4 0->2 above -0.5: late
    step(0, -1);   // R4 2->0 above -0.5: early
    step(2, -3);   // R4 0->2 below -0.5: early
    step(3, 5);    // R6 2->3
    step(2, -5);   // R6 3->2
    doReset();     // R9 mid-run reset
    step(0, 5);    // R9 silent after reset
    step(3, 5);    // R2 0->3 above: late
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3), 2 * $urandom_range(0, 5) - 5);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule